// File: doc/BRIEF.md
# Protected-Register Unlock Gate

This block keeps a group of protected control registers closed until software writes a three-byte key to a single key register on a simple register bus (write strobe, address, write data). It decodes writes to the key address, steps a small sequencer through the key, and raises a lock-state output once the last key byte lands. It also drives a write qualifier, `prot_wr_en`, that the protected registers elsewhere AND with their own address decode. While protection is on, writes to those registers are dropped without any error.

Reading the key address returns the unlock status in bit 0. All other bits read as zero, so the key byte itself can never be read back. Any later write to the key address while the gate is open closes it again. A small 9-bit example protected register at its own address shows the gating at the ports.

Top module: `reg_unlock_gate`

## Requirements
- R1: `unlocked` rises only after three writes to the key address (0x100), with low bytes 0x59, 0x16 and 0x88 in that order. It reads 1 from the first clock edge after the 0x88 write.
- R2: Out of reset, `unlocked` is 0, the example register `demo_q` is 0 and `bus_rdata` at the key address is 0.
- R3: While `unlocked` is 0, `prot_wr_en` stays 0 and a write to the example register address (0x018) leaves `demo_q` unchanged.
- R4: A read of the key address returns `unlocked` in bit 0 and zeros in bits 31:1, whatever was last written. Only bits 7:0 of a key write take part in the comparison.
- R5: A key byte that does not match the expected next byte sends the sequencer back to its start. If that byte is 0x59, it counts as the first step of a new attempt.
- R6: Any key-address write while unlocked makes `unlocked` 0 from the next edge. If that byte is 0x59, it also starts a new attempt, which 0x16 and then 0x88 complete.
- R7: Writes to addresses other than the key address, placed between key bytes, neither advance nor break the sequence.
- R8: `prot_wr_en` follows `bus_wr` combinationally in the same cycle when unlocked and the address is not the key address, and is never high for a key-address write. A qualified write to 0x018 loads `bus_wdata[8:0]` into `demo_q` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address for write and read |
| bus_wdata | input | 32 | Write data; key byte in bits 7:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| unlocked | output | 1 | 1 when protected writes are allowed |
| prot_wr_en | output | 1 | Qualified write strobe for protected registers |
| demo_q | output | 9 | Example protected register contents |

## Verification
`prot_wr_en` and `bus_rdata` are combinational. The bench samples them 1 ns after driving the inputs, before the clock edge that would commit the write. `unlocked` and `demo_q` change on the edge that takes the write, so the bench samples them 1 ns after that rising edge and before the next stimulus at the falling edge. The expected qualifier for each vector comes from the lock state expected before that vector, which checks that no cycle of latency is added.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
   typedef enum logic [1:0] {
      ST_LOCKED = 2'd0,
      ST_KEY1   = 2'd1,
      ST_KEY2   = 2'd2,
      ST_OPEN   = 2'd3
   } ulk_state_e;
endpackage

// File: rtl/ulk_key_seq.sv
module ulk_key_seq
   import unlock_pkg::*;
#(
   parameter logic [7:0] KEY_A = 8'h59,
   parameter logic [7:0] KEY_B = 8'h16,
   parameter logic [7:0] KEY_C = 8'h88
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_byte,
   output logic       unlocked
);
   generate
      if (KEY_A == KEY_B || KEY_A == KEY_C) begin : g_bad_key
         $error("ulk_key_seq: first key byte must differ from the others");
      end
   endgenerate

   ulk_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (key_wr) begin
         if (key_byte == KEY_A) begin
            state_d = ST_KEY1;
         end else begin
            case (state_q)
               ST_KEY1: state_d = (key_byte == KEY_B) ? ST_KEY2 : ST_LOCKED;
               ST_KEY2: state_d = (key_byte == KEY_C) ? ST_OPEN : ST_LOCKED;
               default: state_d = ST_LOCKED;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == ST_OPEN);

   AST_UNLOCK_NEEDS_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && key_byte == KEY_C)); // R1
   AST_RESTART_ON_FIRST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_byte == KEY_A) |=> (state_q == ST_KEY1)); // R5
   AST_KEY_WRITE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && key_wr) |=> !unlocked); // R6
   AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !key_wr |=> $stable(state_q)); // R7
endmodule

// File: rtl/ulk_wr_gate.sv
module ulk_wr_gate #(
   parameter int unsigned     ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h100
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              unlocked,
   output logic              key_wr,
   output logic              wr_qual
);
   logic key_hit;
   assign key_hit = (bus_addr == KEY_ADDR);
   assign key_wr  = bus_wr && key_hit;
   assign wr_qual = bus_wr && !key_hit && unlocked;
endmodule

// File: rtl/ulk_demo_reg.sv
module ulk_demo_reg #(
   parameter int unsigned       ADDR_W    = 12,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       DEMO_W    = 9,
   parameter logic [ADDR_W-1:0] DEMO_ADDR = 12'h018
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_qual,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DEMO_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (wr_qual && bus_addr == DEMO_ADDR) q <= bus_wdata[DEMO_W-1:0];
   end
endmodule

// File: rtl/reg_unlock_gate.sv
module reg_unlock_gate #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEMO_W    = 9,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h100,
   parameter logic [ADDR_W-1:0] DEMO_ADDR = 12'h018,
   parameter logic [7:0] KEY_A = 8'h59,
   parameter logic [7:0] KEY_B = 8'h16,
   parameter logic [7:0] KEY_C = 8'h88
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              unlocked,
   output logic              prot_wr_en,
   output logic [DEMO_W-1:0] demo_q
);
   localparam int unsigned KEY_W = 8;

   generate
      if (DATA_W < KEY_W) begin : g_bad_data_w
         $error("reg_unlock_gate: data width below key width");
      end
      if (DEMO_W == 0 || DEMO_W > DATA_W) begin : g_bad_demo_w
         $error("reg_unlock_gate: example register width out of range");
      end
      if (KEY_ADDR == DEMO_ADDR) begin : g_bad_addr
         $error("reg_unlock_gate: key and example addresses overlap");
      end
   endgenerate

   logic key_wr;

   ulk_wr_gate #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_gate (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .unlocked (unlocked),
      .key_wr   (key_wr),
      .wr_qual  (prot_wr_en)
   );

   ulk_key_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B), .KEY_C(KEY_C)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_byte (bus_wdata[KEY_W-1:0]),
      .unlocked (unlocked)
   );

   ulk_demo_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEMO_W(DEMO_W),
                  .DEMO_ADDR(DEMO_ADDR)) u_demo (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_qual   (prot_wr_en),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .q         (demo_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == KEY_ADDR)       bus_rdata[0]          = unlocked;
      else if (bus_addr == DEMO_ADDR) bus_rdata[DEMO_W-1:0] = demo_q;
   end

   AST_LOCKED_DEMO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(demo_q)); // R3
   AST_NO_QUAL_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> !prot_wr_en); // R3
   AST_KEY_NEVER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == KEY_ADDR) |-> !prot_wr_en); // R8
   AST_STATUS_ONLY_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == KEY_ADDR) |-> (bus_rdata[DATA_W-1:1] == '0)); // R4
endmodule

// File: tb/reg_unlock_gate_tb_top.sv
`timescale 1ns/1ps
module reg_unlock_gate_tb_top;
   localparam logic [11:0] KA = 12'h100;
   localparam logic [11:0] DA = 12'h018;
   localparam logic [11:0] OA = 12'h020;
   localparam int NV = 28;
   // {wr, addr, wdata, expected unlocked after edge, expected demo_q after edge}
   localparam logic [54:0] VEC [0:NV-1] = '{
      {1'b1, DA, 32'h0000_01AB, 1'b0, 9'h000}, // R3 locked write dropped
      {1'b1, KA, 32'h0000_0059, 1'b0, 9'h000}, // R1
      {1'b1, KA, 32'h0000_0016, 1'b0, 9'h000}, // R1
      {1'b1, KA, 32'h0000_0088, 1'b1, 9'h000}, // R1 open
      {1'b1, DA, 32'h0000_00A5, 1'b1, 9'h0A5}, // R8
      {1'b1, KA, 32'h0000_0000, 1'b0, 9'h0A5}, // R6 relock
      {1'b1, DA, 32'h0000_01FF, 1'b0, 9'h0A5}, // R3
      {1'b1, KA, 32'h0000_0059, 1'b0, 9'h0A5}, // R5
      {1'b1, KA, 32'h0000_0059, 1'b0, 9'h0A5}, // R5 restart
      {1'b1, KA, 32'h0000_0016, 1'b0, 9'h0A5}, // R5
      {1'b1, OA, 32'h0000_0000, 1'b0, 9'h0A5}, // R7 foreign
      {1'b1, DA, 32'h0000_0111, 1'b0, 9'h0A5}, // R7 foreign, R3
      {1'b1, KA, 32'h0000_0088, 1'b1, 9'h0A5}, // R7 R5 open
      {1'b1, KA, 32'h0000_0059, 1'b0, 9'h0A5}, // R6 restart relocks
      {1'b1, KA, 32'h0000_0016, 1'b0, 9'h0A5}, // R6
      {1'b1, KA, 32'h0000_0088, 1'b1, 9'h0A5}, // R6 reopen
      {1'b0, DA, 32'h0000_0000, 1'b1, 9'h0A5}, // R8 no strobe
      {1'b1, KA, 32'h0000_0016, 1'b0, 9'h0A5}, // R6
      {1'b1, KA, 32'h0000_0016, 1'b0, 9'h0A5}, // R5
      {1'b1, KA, 32'h0000_0059, 1'b0, 9'h0A5}, // R5
      {1'b1, KA, 32'h0000_0088, 1'b0, 9'h0A5}, // R5 wrong order
      {1'b1, KA, 32'h0000_0016, 1'b0, 9'h0A5}, // R5
      {1'b1, KA, 32'h0000_0088, 1'b0, 9'h0A5}, // R5
      {1'b1, KA, 32'hABCD_0059, 1'b0, 9'h0A5}, // R4 upper bits ignored
      {1'b1, KA, 32'h1234_5616, 1'b0, 9'h0A5}, // R4
      {1'b1, KA, 32'hFFFF_0088, 1'b1, 9'h0A5}, // R4 open
      {1'b1, DA, 32'h7FFF_F0C3, 1'b1, 9'h0C3}, // R8
      {1'b1, OA, 32'h0000_0001, 1'b1, 9'h0C3}  // R7 R8
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        unlocked;
   logic        prot_wr_en;
   logic [8:0]  demo_q;
   int checks = 0;
   int fails = 0;
   logic exp_unl = 1'b0;

   always #2 clk = ~clk;

   reg_unlock_gate dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlocked(unlocked),
      .prot_wr_en(prot_wr_en), .demo_q(demo_q)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic e_unl, input logic [8:0] e_demo, input string req);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      #1;
      check({req, " R8 qual"}, {31'd0, prot_wr_en}, {31'd0, wr && (a != KA) && exp_unl});
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      check({req, " unlocked"}, {31'd0, unlocked}, {31'd0, e_unl});
      check({req, " demo_q"}, {23'd0, demo_q}, {23'd0, e_demo});
      exp_unl = e_unl;
   endtask

   initial begin
      #20000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bus_addr = KA;
      #1;
      check("R2 reset unlocked", {31'd0, unlocked}, 32'd0);
      check("R2 reset rdata", bus_rdata, 32'd0);
      check("R2 reset demo", {23'd0, demo_q}, 32'd0);
      #10 rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][54], VEC[i][53:42], VEC[i][41:10], VEC[i][9], VEC[i][8:0],
              $sformatf("vec%0d", i));
      end

      // R4: status readback while open, key byte never visible
      @(negedge clk);
      bus_addr = KA;
      #1;
      check("R4 rdata open", bus_rdata, 32'h1);
      bus_addr = DA;
      #1;
      check("R4 demo read", bus_rdata, 32'h0C3);
      // R6: relock, then status reads 0 at key address
      step(1'b1, KA, 32'h0000_00FF, 1'b0, 9'h0C3, "R6 relock");
      bus_addr = KA;
      #1;
      check("R4 rdata locked", bus_rdata, 32'h0);
      // R2: reset while open closes the gate
      step(1'b1, KA, 32'h59, 1'b0, 9'h0C3, "R1");
      step(1'b1, KA, 32'h16, 1'b0, 9'h0C3, "R1");
      step(1'b1, KA, 32'h88, 1'b1, 9'h0C3, "R1");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R2 reset relock", {31'd0, unlocked}, 32'd0);
      check("R2 reset demo clear", {23'd0, demo_q}, 32'd0);
      exp_unl = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, DA, 32'h1, 1'b0, 9'h0, "R3 after reset");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule